// File: doc/BRIEF.md
# External Interrupt Request Latch

This block gathers external interrupt requests from one dedicated request pin and from four general port pins that can optionally act as extra request sources. Every pin is brought into the clock domain through a synchronizer chain and then watched for a low-to-high transition. A configurable sensitivity also treats a steady high level as a request. Any qualifying event sets a single request latch. The latch output goes to the processor core as a pending flag.

The core combines the pending flag with its own interrupt mask and with an instruction-boundary strobe. A take signal tells it when to start the interrupt sequence; that signal also depends on an enable bit held in the block's control register. The core pulses a vector-fetch input while it fetches the interrupt vector, and this clears the latch, so a fresh edge during the service routine is caught again. In level mode, a wired-OR source that keeps its pin high keeps setting the latch, so the request is serviced until every source lets go. A small register port gives access to the enable bit, the configuration bits, a read-only view of the latch and a write-one-to-clear acknowledge.

Top module: `eirq_latch`

## Requirements
- R1: After reset, irq_pending is 0 and every register bit reads 0: control (address 0) and configuration (address 1).
- R2: A rising edge on irq_pin sets irq_pending on the third rising clock edge after the pin changes (two synchronizer flops plus the latch).
- R3: While configuration bit 0 (port enable) is 0, activity on port_pins never sets the latch.
- R4: While configuration bit 0 is 1, a rising edge on any port_pins bit sets irq_pending with the same three-edge latency as R2.
- R5: With configuration bit 1 (level mode) at 0, a pin that stays high after the latch has been cleared does not set it again.
- R6: With configuration bit 1 at 1, a high level on any enabled pin sets the latch. While the level persists, a vector fetch does not leave the latch cleared. Once the level is gone, a vector fetch clears it.
- R7: A one-cycle vector_fetch pulse clears irq_pending at the next clock edge, and a later rising edge sets it again.
- R8: When a set event and a vector fetch fall in the same cycle, the latch ends up set.
- R9: take_interrupt is 1 exactly when irq_pending is 1, control bit 0 (enable) is 1, cpu_mask is 0 and instr_boundary is 1.
- R10: Control register bit 0 is the read/write enable, bit 1 is a read-only copy of the latch that writes do not change, and bit 2 reads 0. Configuration bits 0 and 1 are read/write. Read data is registered and appears one cycle after reg_rd.
- R11: Writing 1 to control bit 2 clears the latch at that clock edge, and the enable bit takes the written bit 0.
- R12: A pin that is already high while reset is asserted does not produce a request after reset is released in edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin | input | 1 | Dedicated external request pin (asynchronous) |
| port_pins | input | N_PORT | Port pins usable as extra request sources (asynchronous) |
| cpu_mask | input | 1 | Core interrupt mask, 1 blocks the take signal |
| instr_boundary | input | 1 | High in the cycle the core finishes an instruction |
| vector_fetch | input | 1 | High while the core fetches the interrupt vector; clears the latch |
| reg_addr | input | ADDR_W | Register address (0 control, 1 configuration) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq_pending | output | 1 | Request latch state to the core |
| take_interrupt | output | 1 | Start-interrupt indication to the core |

## Verification
The bench builds the block with its defaults: four port pins, two synchronizer stages and an 8-bit register port. With these values the three-edge pin-to-pending latency is fixed, so the bench can place a vector fetch in exactly the cycle a fresh edge lands and check the set-wins case. The four port pins allow a wired source on a high pin to be compared with the dedicated pin, and the same stimulus can be run under edge and level sensitivity.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  // register addresses
  localparam int REG_CTRL = 0;
  localparam int REG_CFG  = 1;

  // control register bit positions
  localparam int CTRL_IEN_BIT  = 0;
  localparam int CTRL_PEND_BIT = 1;
  localparam int CTRL_ACK_BIT  = 2;

  // configuration register bit positions
  localparam int CFG_PORT_BIT  = 0;
  localparam int CFG_LEVEL_BIT = 1;

  typedef struct packed {
    logic level_mode;
    logic port_en;
  } eirq_cfg_t;

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  // chain keeps running through reset so the edge stage can preload
  always_ff @(posedge clk) begin
    stg[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/eirq_edge.sv
module eirq_edge #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] sync_in,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] high
);

  logic [WIDTH-1:0] prev;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    // previous value follows the pin also during reset, so a pin already
    // high at release is not seen as an edge
    always_ff @(posedge clk) begin
      prev[i] <= sync_in[i];
    end

    assign rise[i] = sync_in[i] & ~prev[i];
    assign high[i] = sync_in[i];

    // R2
    rise_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> !rise[i]);
  end

endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import eirq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pending,
  output logic [DATA_W-1:0] rdata,
  output logic              ien,
  output eirq_cfg_t         cfg,
  output logic              ack_pulse
);

  logic              hit_ctrl;
  logic              hit_cfg;
  logic              wr_ctrl;
  logic              wr_cfg;
  logic [DATA_W-1:0] rd_mux;

  assign hit_ctrl  = (addr == ADDR_W'(REG_CTRL));
  assign hit_cfg   = (addr == ADDR_W'(REG_CFG));
  assign wr_ctrl   = wr_en & hit_ctrl;
  assign wr_cfg    = wr_en & hit_cfg;
  assign ack_pulse = wr_ctrl & wdata[CTRL_ACK_BIT];

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) begin
      rd_mux[CTRL_IEN_BIT]  = ien;
      rd_mux[CTRL_PEND_BIT] = pending;
    end else if (hit_cfg) begin
      rd_mux[CFG_PORT_BIT]  = cfg.port_en;
      rd_mux[CFG_LEVEL_BIT] = cfg.level_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien   <= 1'b0;
      cfg   <= '0;
      rdata <= '0;
    end else begin
      if (wr_ctrl) ien <= wdata[CTRL_IEN_BIT];
      if (wr_cfg) begin
        cfg.port_en    <= wdata[CFG_PORT_BIT];
        cfg.level_mode <= wdata[CFG_LEVEL_BIT];
      end
      if (rd_en) rdata <= rd_mux;
    end
  end

  // R10
  ien_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_ctrl |=> $stable(ien));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_cfg |=> $stable(cfg));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

endmodule

// File: rtl/eirq_latch.sv
module eirq_latch
  import eirq_pkg::*;
#(
  parameter int N_PORT      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_pin,
  input  logic [N_PORT-1:0] port_pins,
  input  logic              cpu_mask,
  input  logic              instr_boundary,
  input  logic              vector_fetch,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_pending,
  output logic              take_interrupt
);

  localparam int NPIN = N_PORT + 1;

  logic [NPIN-1:0] pins_raw;
  logic [NPIN-1:0] pins_sync;
  logic [NPIN-1:0] pin_rise;
  logic [NPIN-1:0] pin_high;
  logic [NPIN-1:0] pin_en;
  logic            ien;
  eirq_cfg_t       cfg;
  logic            ack_pulse;
  logic            rise_any;
  logic            high_any;
  logic            set_evt;
  logic            clr_evt;
  logic            latch_q;

  // bit 0 is the dedicated pin, upper bits the port pins
  assign pins_raw = {port_pins, irq_pin};

  eirq_sync #(
    .WIDTH (NPIN),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .din (pins_raw),
    .dout(pins_sync)
  );

  eirq_edge #(
    .WIDTH(NPIN)
  ) u_edge (
    .clk    (clk),
    .rst    (rst),
    .sync_in(pins_sync),
    .rise   (pin_rise),
    .high   (pin_high)
  );

  eirq_regs #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr     (reg_addr),
    .wr_en    (reg_wr),
    .rd_en    (reg_rd),
    .wdata    (reg_wdata),
    .pending  (latch_q),
    .rdata    (reg_rdata),
    .ien      (ien),
    .cfg      (cfg),
    .ack_pulse(ack_pulse)
  );

  assign pin_en   = {{N_PORT{cfg.port_en}}, 1'b1};
  assign rise_any = |(pin_rise & pin_en);
  assign high_any = |(pin_high & pin_en);
  assign set_evt  = rise_any | (cfg.level_mode & high_any);
  assign clr_evt  = vector_fetch | ack_pulse;

  // set has priority so an edge landing with a clear is kept
  always_ff @(posedge clk) begin
    if (rst)          latch_q <= 1'b0;
    else if (set_evt) latch_q <= 1'b1;
    else if (clr_evt) latch_q <= 1'b0;
  end

  assign irq_pending    = latch_q;
  assign take_interrupt = latch_q & ien & ~cpu_mask & instr_boundary;

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> irq_pending);

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_evt && !set_evt) |=> !irq_pending);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_evt && !set_evt) |=> $stable(irq_pending));

  // R3
  port_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg.port_en && !pin_rise[0] && !(cfg.level_mode && pin_high[0]) && !irq_pending)
      |=> !irq_pending);

  // R9
  take_gate_chk: assert property (@(posedge clk) disable iff (rst)
    take_interrupt |-> (irq_pending && !cpu_mask));

endmodule

// File: tb/eirq_latch_tb.sv
module eirq_latch_tb;
  import eirq_pkg::*;

  localparam int N_PORT = 4;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              irq_pin = 1'b0;
  logic [N_PORT-1:0] port_pins = '0;
  logic              cpu_mask = 1'b0;
  logic              instr_boundary = 1'b0;
  logic              vector_fetch = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              irq_pending;
  logic              take_interrupt;

  always #2.5 clk = ~clk;

  eirq_latch #(
    .N_PORT(N_PORT), .SYNC_STAGES(2), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dut (
    .clk(clk), .rst(rst), .irq_pin(irq_pin), .port_pins(port_pins),
    .cpu_mask(cpu_mask), .instr_boundary(instr_boundary),
    .vector_fetch(vector_fetch), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pending(irq_pending), .take_interrupt(take_interrupt)
  );

  // kind: 0 pending, 1 take, 2 read data
  typedef struct {
    string      req;
    int         kind;
    logic [7:0] exp;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  // monitor: pops expectations and compares with the ports
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        logic [7:0] act;
        e = exp_q.pop_front();
        case (e.kind)
          0:       act = {7'd0, irq_pending};
          1:       act = {7'd0, take_interrupt};
          default: act = reg_rdata;
        endcase
        checks++;
        if (act !== e.exp) begin
          errors++;
          $display("FAIL %s kind=%0d actual=%0h expected=%0h", e.req, e.kind, act, e.exp);
        end
      end
    end
  end

  task automatic expect_val(input string req, input int kind, input logic [7:0] v);
    exp_t e;
    e.req = req; e.kind = kind; e.exp = v;
    exp_q.push_back(e);
    -> chk_ev;
    #1;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_write(input int a, input logic [7:0] d);
    reg_addr = ADDR_W'(a); reg_wdata = d; reg_wr = 1'b1;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input string req, input int a, input logic [7:0] v);
    reg_addr = ADDR_W'(a); reg_rd = 1'b1;
    tick(1);
    reg_rd = 1'b0;
    expect_val(req, 2, v);
  endtask

  task automatic vf_pulse();
    vector_fetch = 1'b1;
    tick(1);
    vector_fetch = 1'b0;
  endtask

  // watchdog
  initial begin
    #(5ns * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    irq_pin = 1'b1;                    // high during reset (R12)
    rst = 1'b1;
    tick(5);
    rst = 1'b0;
    tick(4);
    expect_val("R1 R12 pending after reset", 0, 8'd0);
    reg_read("R1 ctrl reset", REG_CTRL, 8'h00);
    reg_read("R1 cfg reset", REG_CFG, 8'h00);

    // R2 dedicated pin edge latency
    irq_pin = 1'b0; tick(4);
    irq_pin = 1'b1;
    tick(2);
    expect_val("R2 not yet set after two edges", 0, 8'd0);
    tick(1);
    expect_val("R2 set on third edge", 0, 8'd1);

    // R9 take gating
    instr_boundary = 1'b1;
    expect_val("R9 take blocked by enable", 1, 8'd0);
    reg_write(REG_CTRL, 8'h01);
    expect_val("R9 take asserted", 1, 8'd1);
    cpu_mask = 1'b1; #1;
    expect_val("R9 take blocked by mask", 1, 8'd0);
    cpu_mask = 1'b0; instr_boundary = 1'b0; #1;
    expect_val("R9 take waits for boundary", 1, 8'd0);
    reg_read("R10 ctrl shows enable and pending", REG_CTRL, 8'h03);

    // R7 vector fetch clear, R5 held pin does not re-arm
    vf_pulse();
    expect_val("R7 cleared by vector fetch", 0, 8'd0);
    tick(5);
    expect_val("R5 held pin in edge mode", 0, 8'd0);

    // R10 pending bit is read-only
    reg_write(REG_CTRL, 8'h03);
    expect_val("R10 pending write ignored", 0, 8'd0);
    reg_read("R10 ctrl after write", REG_CTRL, 8'h01);

    // R3 port pins disabled
    irq_pin = 1'b0; tick(4);
    port_pins = 4'hF; tick(5);
    expect_val("R3 port pins ignored", 0, 8'd0);

    // R4 port pin enabled
    port_pins = 4'h0; tick(4);
    reg_write(REG_CFG, 8'h01);
    reg_read("R10 cfg readback", REG_CFG, 8'h01);
    port_pins = 4'h4;
    tick(3);
    expect_val("R4 port pin edge sets", 0, 8'd1);

    // R11 acknowledge clears
    reg_write(REG_CTRL, 8'h05);
    expect_val("R11 ack clears latch", 0, 8'd0);
    reg_read("R11 ack reads zero, enable kept", REG_CTRL, 8'h01);

    // R7 relatch on a later edge
    port_pins = 4'h0; tick(4);
    port_pins = 4'h1; tick(3);
    expect_val("R7 relatched", 0, 8'd1);
    vf_pulse();
    port_pins = 4'h0; tick(4);

    // R8 set and clear in the same cycle
    port_pins = 4'h8;
    tick(2);
    vector_fetch = 1'b1;
    tick(1);
    vector_fetch = 1'b0;
    expect_val("R8 set wins over clear", 0, 8'd1);
    vf_pulse();
    expect_val("R8 later clear works", 0, 8'd0);

    // R6 level mode with pin still high
    reg_write(REG_CFG, 8'h03);
    tick(1);
    expect_val("R6 level sets", 0, 8'd1);
    vf_pulse();
    expect_val("R6 level re-arms after fetch", 0, 8'd1);
    port_pins = 4'h0;
    tick(2);
    vf_pulse();
    expect_val("R6 clear after level gone", 0, 8'd0);
    reg_read("R10 cfg level readback", REG_CFG, 8'h03);

    // R6 dedicated pin in level mode
    irq_pin = 1'b1; tick(3);
    expect_val("R6 dedicated pin level", 0, 8'd1);

    tick(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule